// File: doc/BRIEF.md
# Gated Timer/Counter with Two Counting Modes

This block is a single 8-bit-register timer/counter peripheral. It counts events from one of two sources: a divide-by-six tick taken from the system clock, or falling edges of an external count pin. Counting runs while a run bit is set. When the gate bit is also set, the count only moves while an external active-low gate pin, seen through a synchronizer, reads high. A small state machine holds the run condition in three states: `ST_STOP` (run bit clear), `ST_GATED` (run bit set, but the gate blocks counting) and `ST_RUN` (counting).

The counter has two modes. In the 16-bit mode the low and high count registers form one counter. In the 13-bit mode the five low bits of the low register act as a modulo-32 prescaler, and its wrap advances the high register. The top three bits of the low register then play no part in counting. When the count wraps to zero, an overflow flag is set, and the interrupt request output follows that flag. Software reads and writes the count and control registers through a simple register port.

State transitions, all evaluated on the value the run and gate bits will hold after the current cycle: `ST_STOP`→`ST_RUN` or `ST_STOP`→`ST_GATED` on a control write that sets the run bit, chosen by the gate condition. `ST_RUN`→`ST_GATED` when the gate bit is set and the synchronized gate pin is low. `ST_GATED`→`ST_RUN` when the gate bit is clear or the synchronized pin is high. `ST_RUN`→`ST_STOP` and `ST_GATED`→`ST_STOP` on a control write that clears the run bit.

Top module: `gtc_timer`

## Requirements
- R1: After reset the low count (address 0), high count (address 1) and control (address 2) registers read 0x00 and `irq` is 0.
- R2: With the source select bit at 0 and the timer running, the count advances once every 6 clock cycles. The first advance lands on the 6th rising edge after the edge that wrote the run bit.
- R3: With the source select bit at 1, each falling edge of `count_in` advances the count once. The advance lands on the 3rd rising edge after the pin falls, because of a two-flop synchronizer and an edge detector.
- R4: While the run bit is 0 the count registers change only by register writes.
- R5: With the gate bit at 1, counting proceeds only while the synchronized `gate_in` reads high. A change of the pin takes effect for the cycle after the 3rd rising edge that follows it.
- R6: In the 16-bit mode (mode bit = 1) the high:low pair counts as one 16-bit value. A step from 0xFFFF gives 0x0000 and sets the overflow flag.
- R7: In the 13-bit mode (mode bit = 0) bits 4:0 of the low register count modulo 32, and each wrap increments the high register. A wrap while high is 0xFF sets the overflow flag. Bits 7:5 of the low register keep their written value and do not affect counting.
- R8: `irq` equals the overflow flag. The flag clears on an `irq_ack` pulse or on a control write with bit 4 at 0. An overflow in the same cycle wins over the clear.
- R9: A write to the low or high count register in the cycle of a count event takes the written value, and that count event is dropped.
- R10: The control register is laid out as bit 0 run, bit 1 source select, bit 2 gate, bit 3 mode, bit 4 overflow flag, bits 7:5 zero. Address 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low, 1 high, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational on `rd_addr` |
| count_in | input | 1 | External count pin, falling edge counts |
| gate_in | input | 1 | External active-low gate pin |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| irq | output | 1 | Interrupt request, equal to the overflow flag |

## Verification
Register writes and overflow results are visible one rising edge after the cycle that caused them. An internal tick lands 6 edges after the run write. A `count_in` fall lands on the 3rd edge, and a `gate_in` change alters the state on the 3rd edge. The bench drives every input half a cycle before a rising edge and steps its own model once per edge. It reads all four addresses and `irq` before the next edge. The directed literal checks count exactly these edge offsets, so a one-cycle slip in any path shows up as a miscompare.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_GATED = 2'd1,
        ST_RUN   = 2'd2
    } state_t;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CB_RUN  = 0;
    localparam int CB_SEL  = 1;
    localparam int CB_GATE = 2;
    localparam int CB_MODE = 3;
    localparam int CB_FLAG = 4;

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gtc_ctrl_fsm.sv
module gtc_ctrl_fsm
    import gtc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ctrl_wr,
    input  logic   wr_run,
    input  logic   wr_gate,
    input  logic   gate_q,
    input  logic   gate_lvl,
    output state_t state,
    output logic   running,
    output logic   run_bit
);
    state_t nxt;
    logic   nrun;
    logic   ngate;

    always_comb begin
        nrun  = ctrl_wr ? wr_run  : (state != ST_STOP);
        ngate = ctrl_wr ? wr_gate : gate_q;
        nxt   = state;
        unique case (state)
            ST_STOP: begin
                if (nrun) nxt = (ngate && !gate_lvl) ? ST_GATED : ST_RUN;
            end
            ST_GATED: begin
                if (!nrun)                  nxt = ST_STOP;
                else if (!ngate || gate_lvl) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!nrun)                  nxt = ST_STOP;
                else if (ngate && !gate_lvl) nxt = ST_GATED;
            end
            default: nxt = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_STOP;
        else        state <= nxt;
    end

    always_comb begin
        running = (state == ST_RUN);
        run_bit = (state != ST_STOP);
    end
endmodule

// File: rtl/gtc_event.sv
module gtc_event #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic sel_ext,
    input  logic cnt_lvl,
    output logic ev
);
    localparam int DIV_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic             prev_lvl;
    logic             fall;
    logic             tick;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            prev_lvl <= 1'b1;
        end else begin
            prev_lvl <= cnt_lvl;
            if (!running)              div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                       div_q <= div_q + DIV_W'(1);
        end
    end

    assign fall = prev_lvl && !cnt_lvl;
    assign tick = (div_q == DIV_LAST);
    assign ev   = running && (sel_ext ? fall : tick);
endmodule

// File: rtl/gtc_counter.sv
module gtc_counter #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             mode16,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] lo,
    output logic [CNT_W-1:0] hi,
    output logic             ovf
);
    localparam int W2 = 2 * CNT_W;

    logic             ev_eff;
    logic [CNT_W-1:0] nlo;
    logic [CNT_W-1:0] nhi;
    logic [W2-1:0]    sum16;
    logic [PRE_W-1:0] pre;

    assign ev_eff = ev && !wr_lo && !wr_hi;
    assign sum16  = {hi, lo} + W2'(1);
    assign pre    = lo[PRE_W-1:0];

    always_comb begin
        nlo = lo;
        nhi = hi;
        ovf = 1'b0;
        if (ev_eff) begin
            if (mode16) begin
                nlo = sum16[CNT_W-1:0];
                nhi = sum16[W2-1:CNT_W];
                ovf = (lo == '1) && (hi == '1);
            end else if (pre == '1) begin
                nlo = {lo[CNT_W-1:PRE_W], {PRE_W{1'b0}}};
                nhi = hi + CNT_W'(1);
                ovf = (hi == '1);
            end else begin
                nlo = {lo[CNT_W-1:PRE_W], pre + PRE_W'(1)};
            end
        end
        if (wr_lo) nlo = wr_data;
        if (wr_hi) nhi = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo <= '0;
            hi <= '0;
        end else begin
            lo <= nlo;
            hi <= nhi;
        end
    end
endmodule

// File: rtl/gtc_timer.sv
module gtc_timer
    import gtc_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 5,
    parameter int DIV    = 6,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             count_in,
    input  logic             gate_in,
    input  logic             irq_ack,
    output logic             irq
);
    logic             wr_lo, wr_hi, wr_ctrl;
    logic             sel_q, gate_q, mode16, flag_q;
    logic             cnt_lvl, gate_lvl;
    logic             running, run_bit, ev, ovf;
    logic [CNT_W-1:0] cnt_lo, cnt_hi;
    state_t           state;

    assign wr_lo   = wr_en && (wr_addr == ADDR_LO);
    assign wr_hi   = wr_en && (wr_addr == ADDR_HI);
    assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);

    gtc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .d(count_in), .q(cnt_lvl));

    gtc_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_gate_sync (
        .clk(clk), .rst_n(rst_n), .d(gate_in), .q(gate_lvl));

    gtc_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl),
        .wr_run(wr_data[CB_RUN]), .wr_gate(wr_data[CB_GATE]),
        .gate_q(gate_q), .gate_lvl(gate_lvl),
        .state(state), .running(running), .run_bit(run_bit));

    gtc_event #(.DIV(DIV)) u_event (
        .clk(clk), .rst_n(rst_n), .running(running),
        .sel_ext(sel_q), .cnt_lvl(cnt_lvl), .ev(ev));

    gtc_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .ev(ev), .mode16(mode16),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .lo(cnt_lo), .hi(cnt_hi), .ovf(ovf));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            gate_q <= 1'b0;
            mode16 <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                sel_q  <= wr_data[CB_SEL];
                gate_q <= wr_data[CB_GATE];
                mode16 <= wr_data[CB_MODE];
            end
            if (ovf)                                  flag_q <= 1'b1;
            else if (irq_ack || (wr_ctrl && !wr_data[CB_FLAG])) flag_q <= 1'b0;
        end
    end

    assign irq = flag_q;

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_LO:   rd_data = cnt_lo;
            ADDR_HI:   rd_data = cnt_hi;
            ADDR_CTRL: begin
                rd_data[CB_RUN]  = run_bit;
                rd_data[CB_SEL]  = sel_q;
                rd_data[CB_GATE] = gate_q;
                rd_data[CB_MODE] = mode16;
                rd_data[CB_FLAG] = flag_q;
            end
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/gtc_timer_checks.sv
module gtc_timer_checks
    import gtc_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq,
    input logic             irq_ack,
    input logic             ovf,
    input logic             wr_lo,
    input logic             wr_hi,
    input logic             mode16,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt_lo,
    input logic [CNT_W-1:0] cnt_hi,
    input state_t           state
);
    p_ovf_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> irq);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !ovf) |=> !irq);

    p_irq_needs_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !ovf) |=> !irq);

    p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    p_gated_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GATED && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_lo == $past(wr_data)));

    p_upper_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode16 && !wr_lo) |=> $stable(cnt_lo[CNT_W-1:PRE_W]));

    p_ovf_wraps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_hi == '0 &&
                 ($past(mode16) ? (cnt_lo == '0) : (cnt_lo[PRE_W-1:0] == '0))));
endmodule

bind gtc_timer gtc_timer_checks #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq(irq), .irq_ack(irq_ack), .ovf(ovf),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .mode16(mode16), .wr_data(wr_data),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .state(state));

// File: tb/gtc_timer_bench.sv
module gtc_timer_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_addr = 2'd0;
    logic [7:0] rd_data;
    logic       count_in = 1'b1;
    logic       gate_in = 1'b1;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rdv [4];
    logic       irqv;

    // reference state
    logic [7:0] m_lo, m_hi;
    logic       m_sel, m_gate, m_mode, m_flag;
    int         m_st;      // 0 stopped, 1 gated, 2 running
    int         m_div;
    logic       m_c1, m_c2, m_prev, m_g1, m_g2;

    always #(PERIOD/2) clk = ~clk;

    gtc_timer u_gtc_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .count_in(count_in), .gate_in(gate_in), .irq_ack(irq_ack), .irq(irq));

    task automatic model_reset();
        m_lo = 8'd0; m_hi = 8'd0; m_sel = 0; m_gate = 0; m_mode = 0; m_flag = 0;
        m_st = 0; m_div = 0;
        m_c1 = 1; m_c2 = 1; m_prev = 1; m_g1 = 1; m_g2 = 1;
    endtask

    function automatic logic [7:0] model_read(input int a);
        case (a)
            0: return m_lo;
            1: return m_hi;
            2: return {3'b000, m_flag, m_mode, m_gate, m_sel, (m_st != 0)};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_edge();
        logic run_now, ev, wlo, whi, wct, ovf, nrun, ngate;
        logic [7:0] nlo, nhi;
        logic [15:0] s16;
        run_now = (m_st == 2);
        ev  = run_now && (m_sel ? (m_prev && !m_c2) : (m_div == 5));
        wlo = wr_en && wr_addr == 2'd0;
        whi = wr_en && wr_addr == 2'd1;
        wct = wr_en && wr_addr == 2'd2;
        ovf = 0; nlo = m_lo; nhi = m_hi;
        if (ev && !wlo && !whi) begin
            if (m_mode) begin
                ovf = ({m_hi, m_lo} == 16'hFFFF);
                s16 = {m_hi, m_lo} + 16'd1;
                nhi = s16[15:8]; nlo = s16[7:0];
            end else if (m_lo[4:0] == 5'h1F) begin
                nlo = {m_lo[7:5], 5'd0}; nhi = m_hi + 8'd1; ovf = (m_hi == 8'hFF);
            end else begin
                nlo = m_lo + 8'd1;
            end
        end
        if (wlo) nlo = wr_data;
        if (whi) nhi = wr_data;
        if (ovf) m_flag = 1;
        else if (irq_ack || (wct && !wr_data[4])) m_flag = 0;
        nrun  = wct ? wr_data[0] : (m_st != 0);
        ngate = wct ? wr_data[2] : m_gate;
        m_div = run_now ? ((m_div == 5) ? 0 : m_div + 1) : 0;
        m_st  = !nrun ? 0 : ((ngate && !m_g2) ? 1 : 2);
        if (wct) begin m_sel = wr_data[1]; m_gate = wr_data[2]; m_mode = wr_data[3]; end
        m_lo = nlo; m_hi = nhi;
        m_prev = m_c2; m_c2 = m_c1; m_c1 = count_in;
        m_g2 = m_g1; m_g1 = gate_in;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one rising edge: inputs already driven, compare all registers afterwards
    task automatic step(input string tag, input logic we, input logic [1:0] wa,
                        input logic [7:0] wd, input logic ack);
        wr_en = we; wr_addr = wa; wr_data = wd; irq_ack = ack;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        wr_en = 0; irq_ack = 0;
        for (int a = 0; a < 4; a++) begin
            rd_addr = a[1:0];
            #1;
            rdv[a] = rd_data;
            chk(tag, rd_data, model_read(a));
        end
        irqv = irq;
        chk({tag, " irq R8"}, {7'd0, irq}, {7'd0, m_flag});
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 0, 2'd0, 8'd0, 0);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        idle("R1 reset", 1);
        chk("R1 lo", rdv[0], 8'h00); chk("R1 hi", rdv[1], 8'h00);
        chk("R1 ctrl", rdv[2], 8'h00); chk("R1 irq", {7'd0, irqv}, 8'h00);

        // R2 internal tick: run, internal source, 16-bit mode
        step("R2 start", 1, 2'd2, 8'h09, 0);
        idle("R2 wait", 5);
        chk("R2 before 6th edge", rdv[0], 8'h00);
        idle("R2 tick", 1);
        chk("R2 6th edge", rdv[0], 8'h01);
        idle("R2 second", 6);
        chk("R2 12th edge", rdv[0], 8'h02);

        // R4 stopped
        step("R4 stop", 1, 2'd2, 8'h08, 0);
        hold = rdv[0];
        idle("R4 hold", 20);
        chk("R4 no count", rdv[0], hold);

        // R3 + R6 external fall, 16-bit overflow
        step("R6 lo", 1, 2'd0, 8'hFF, 0);
        step("R6 hi", 1, 2'd1, 8'hFF, 0);
        step("R3 run ext", 1, 2'd2, 8'h0B, 0);
        count_in = 0;
        idle("R3 sync", 2);
        chk("R3 before 3rd edge", rdv[0], 8'hFF);
        idle("R3 edge", 1);
        chk("R6 lo wrap", rdv[0], 8'h00); chk("R6 hi wrap", rdv[1], 8'h00);
        chk("R6 irq set", {7'd0, irqv}, 8'h01);
        count_in = 1;
        step("R8 ack", 0, 2'd0, 8'd0, 1);
        chk("R8 ack clears", {7'd0, irqv}, 8'h00);

        // R7 13-bit mode, upper bits of low kept and ignored
        step("R7 stop", 1, 2'd2, 8'h02, 0);
        step("R7 lo", 1, 2'd0, 8'hFF, 0);
        step("R7 hi", 1, 2'd1, 8'hFF, 0);
        step("R7 run", 1, 2'd2, 8'h03, 0);
        count_in = 0;
        idle("R7 sync", 3);
        chk("R7 lo upper kept", rdv[0], 8'hE0); chk("R7 hi wrap", rdv[1], 8'h00);
        chk("R7 overflow irq", {7'd0, irqv}, 8'h01);

        // R9 write beats a count event in the same cycle
        count_in = 1;
        idle("R9 settle", 3);
        count_in = 0;
        idle("R9 sync", 2);
        step("R9 collide", 1, 2'd0, 8'h10, 0);
        chk("R9 written value", rdv[0], 8'h10); chk("R9 hi unchanged", rdv[1], 8'h00);
        idle("R9 after", 2);
        chk("R9 event dropped", rdv[0], 8'h10);

        // R8 clear by control write, R10 layout and address 3
        step("R8 ctrl clear", 1, 2'd2, 8'h03, 0);
        chk("R8 ctrl clears", {7'd0, irqv}, 8'h00);
        chk("R10 ctrl layout", rdv[2], 8'h03);
        step("R10 addr3 write", 1, 2'd3, 8'h55, 0);
        chk("R10 addr3 reads 0", rdv[3], 8'h00);
        chk("R10 addr3 no effect lo", rdv[0], 8'h10);
        chk("R10 addr3 no effect ctrl", rdv[2], 8'h03);

        // R5 gate
        count_in = 1;
        step("R5 stop", 1, 2'd2, 8'h00, 0);
        gate_in = 0;
        step("R5 lo", 1, 2'd0, 8'h00, 0);
        idle("R5 sync", 3);
        step("R5 run gated", 1, 2'd2, 8'h05, 0);
        idle("R5 held", 30);
        chk("R5 gated no count", rdv[0], 8'h00);
        chk("R5 run bit shows", rdv[2], 8'h05);
        gate_in = 1;
        idle("R5 open", 20);
        chk("R5 counts after gate opens", rdv[0], 8'h02);

        // random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            logic we, ack;
            logic [1:0] wa;
            logic [7:0] wd;
            if ($urandom_range(2) == 0) count_in = ~count_in;
            if ($urandom_range(19) == 0) gate_in = ~gate_in;
            we  = ($urandom_range(9) == 0);
            wa  = 2'($urandom_range(3));
            wd  = 8'($urandom_range(255));
            if (wa != 2'd2 && $urandom_range(1) == 0) wd = 8'hFF;
            if (wa == 2'd2) wd[0] = ($urandom_range(3) != 0);
            ack = ($urandom_range(15) == 0);
            step("R2 R3 R5 R6 R7 R8 R9 random", we, wa, wd, ack);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule